// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Controller with Dimming and Lamp Flash

This block keeps a panel of common-cathode seven-segment digits lit once the host has written their contents. A host write port fills two internal stores. The first is a numeric bank of six digits, each holding a 4-bit BCD code that is decoded to segments. The second is a segment bank of four positions, each holding seven raw segment bits. Each bank steps through its positions from its own divider and lights one digit at a time. Between two positions every enable of that bank stays off for one clock.

One position of the segment bank holds discrete indicator lamps. Each lamp can be off, steadily on, or flashing with a slow square wave. The numeric bank can be dimmed as a whole. When the `bright` input is low, its digit enables pass only during the high part of a fast 40 % duty waveform. Every divider is derived from the system clock frequency parameter and the wanted rates.

Top module: `seg_display_ctrl`

## Requirements
- R1: While `rst` is high, every digit enable and every segment output is 0. The numeric slots reset to code 15 and the segment slots reset to 0.
- R2: A write with `wr_en` high at a rising edge changes the stored contents from the next cycle on. Addresses 0–5 load `wr_data[3:0]` into numeric slot 0–5. Addresses 8–11 load `wr_data[6:0]` into segment slot 0–3. Addresses 6, 7 and 12–15 change nothing.
- R3: `bcd_seg` shows the decoded code of the numeric slot at the current position. Bit 0 is segment a and bit 6 is segment g. Codes 0–9 map to 3F,06,5B,4F,66,6D,7D,07,7F,6F (hex). Codes 10–15 give 0.
- R4: The numeric bank moves one position every BCD_DIV = CLK_HZ/(BCD_SCAN_HZ·6) cycles, in the order 0,1,…,5,0. Its enable is one-hot at bit `position` unless blanked.
- R5: The segment bank moves one position every RAW_DIV = CLK_HZ/(RAW_SCAN_HZ·4) cycles, in the order 0…3,0. Its enable is one-hot at bit `position`, and it is never dimmed.
- R6: In the first cycle at a new position, all enables of that bank are 0. This also holds for the first cycle after reset.
- R7: A dimming counter runs from reset modulo DIM_DIV = CLK_HZ/DIM_HZ. With `bright` = 1 the numeric enables are not gated. With `bright` = 0 they are 0 whenever the counter is not below DIM_DIV·2/5.
- R8: The flash phase starts at 1 after reset and inverts every FL_HALF = (CLK_HZ/(2·FLASH_DHZ))·10 cycles.
- R9: While the segment bank sits at position 3, each segment whose `lamp_flash_en` bit is 1 is forced to 0 during the flash phase 0. At every other position, and for bits whose flash enable is 0, the stored bit is shown unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write address |
| wr_data | input | 7 | Host write data |
| bright | input | 1 | 1 = full brightness, 0 = dimmed numeric bank |
| lamp_flash_en | input | 7 | Per-lamp flash enable for the lamp position |
| bcd_seg | output | 7 | Numeric bank segments a..g |
| bcd_dig | output | 6 | Numeric bank digit enables |
| raw_seg | output | 7 | Segment bank segments a..g |
| raw_dig | output | 4 | Segment bank digit enables |

## Verification
All outputs are combinational from registered state. A write or a divider step taken at one rising edge therefore shows at the ports during the clock cycle that follows. The position change and the one-cycle blank take effect at the same edge. The bench advances its behavioural model at each rising edge and compares all four outputs at the following falling edge. This puts every expected value in exactly the cycle it is due. Inputs are changed just after a rising edge, so the model and the design see the same values.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    localparam int SEG_W = 7;
    localparam int CODE_W = 4;
    localparam int ADDR_W = 4;
endpackage

// File: rtl/sdc_seg_decode.sv
module sdc_seg_decode
    import sdc_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [SEG_W-1:0]  seg
);
    always_comb begin
        case (code)
            4'd0: seg = 7'h3F;
            4'd1: seg = 7'h06;
            4'd2: seg = 7'h5B;
            4'd3: seg = 7'h4F;
            4'd4: seg = 7'h66;
            4'd5: seg = 7'h6D;
            4'd6: seg = 7'h7D;
            4'd7: seg = 7'h07;
            4'd8: seg = 7'h7F;
            4'd9: seg = 7'h6F;
            default: seg = 7'h00;
        endcase
    end
endmodule

// File: rtl/sdc_pwm.sv
module sdc_pwm #(
    parameter int DIV = 10,
    parameter int ON  = 4,
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst,
    output logic on_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CNT_W'(DIV - 1)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign on_o = ({1'b0, st_q.cnt} < (CNT_W + 1)'(ON));

    // R7: the waveform restarts high at every period boundary
    a_r7_period_start: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == '0) |-> on_o);
endmodule

// File: rtl/sdc_scan_bank.sv
module sdc_scan_bank #(
    parameter int N_POS    = 6,
    parameter int DATA_W   = 4,
    parameter int DIV      = 20,
    parameter logic [DATA_W-1:0] RST_CELL = '0,
    localparam int IDX_W = (N_POS > 1) ? $clog2(N_POS) : 1,
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              gate_on,
    output logic [DATA_W-1:0] cell_o,
    output logic [IDX_W-1:0]  ptr_o,
    output logic [N_POS-1:0]  dig_o
);
    typedef struct packed {
        logic [CNT_W-1:0]             cnt;
        logic [IDX_W-1:0]             ptr;
        logic                         gap;
        logic [N_POS-1:0][DATA_W-1:0] mem;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CNT_W'(DIV - 1)) begin
            st_d.cnt = '0;
            st_d.gap = 1'b1;
            st_d.ptr = (st_q.ptr == IDX_W'(N_POS - 1)) ? '0 : st_q.ptr + 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.gap = 1'b0;
        end
        if (wr_en && (wr_idx <= IDX_W'(N_POS - 1))) begin
            st_d.mem[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= '0;
            st_q.ptr <= '0;
            st_q.gap <= 1'b1;
            st_q.mem <= {N_POS{RST_CELL}};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        dig_o = '0;
        if (!st_q.gap && gate_on) begin
            dig_o[st_q.ptr] = 1'b1;
        end
    end

    assign cell_o = st_q.mem[st_q.ptr];
    assign ptr_o  = st_q.ptr;

    // R4/R5: never more than one digit enabled
    a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dig_o));

    // R6: a position change is always accompanied by a dark cycle
    a_r6_break_before_make: assert property (@(posedge clk) disable iff (rst)
        (st_q.ptr != $past(st_q.ptr)) |-> (dig_o == '0));

    // R4/R5: positions advance by one and wrap at the last
    a_r5_step_order: assert property (@(posedge clk) disable iff (rst)
        (st_q.ptr != $past(st_q.ptr)) |->
        (st_q.ptr == (($past(st_q.ptr) == IDX_W'(N_POS - 1)) ? '0 : $past(st_q.ptr) + 1'b1)));
endmodule

// File: rtl/seg_display_ctrl.sv
module seg_display_ctrl
    import sdc_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int BCD_SCAN_HZ = 300,
    parameter int RAW_SCAN_HZ = 500,
    parameter int DIM_HZ      = 20_000,
    parameter int FLASH_DHZ   = 12,
    parameter int N_BCD       = 6,
    parameter int N_RAW       = 4,
    parameter int LAMP_POS    = 3,
    localparam int BCD_DIV  = CLK_HZ / (BCD_SCAN_HZ * N_BCD),
    localparam int RAW_DIV  = CLK_HZ / (RAW_SCAN_HZ * N_RAW),
    localparam int DIM_DIV  = CLK_HZ / DIM_HZ,
    localparam int DIM_ON   = (DIM_DIV * 2) / 5,
    localparam int FL_HALF  = (CLK_HZ / (2 * FLASH_DHZ)) * 10,
    localparam int FL_W     = $clog2(FL_HALF),
    localparam int BCD_IW   = $clog2(N_BCD),
    localparam int RAW_IW   = $clog2(N_RAW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SEG_W-1:0]  wr_data,
    input  logic              bright,
    input  logic [SEG_W-1:0]  lamp_flash_en,
    output logic [SEG_W-1:0]  bcd_seg,
    output logic [N_BCD-1:0]  bcd_dig,
    output logic [SEG_W-1:0]  raw_seg,
    output logic [N_RAW-1:0]  raw_dig
);
    typedef struct packed {
        logic [FL_W-1:0] cnt;
        logic            phase;
    } fl_t;

    fl_t fl_d, fl_q;

    logic              bcd_we, raw_we, pwm_on, bcd_gate;
    logic [CODE_W-1:0] bcd_cell;
    logic [BCD_IW-1:0] bcd_ptr;
    logic [SEG_W-1:0]  raw_cell;
    logic [RAW_IW-1:0] raw_ptr;
    logic [SEG_W-1:0]  lamp_kill;

    // address map: 0..N_BCD-1 numeric, 8..8+N_RAW-1 segment bank
    always_comb begin
        bcd_we = wr_en && !wr_addr[3] && (wr_addr[2:0] <= 3'(N_BCD - 1));
        raw_we = wr_en && (wr_addr[3:2] == 2'b10) && (wr_addr[1:0] <= 2'(N_RAW - 1));
    end

    // slow flash phase
    always_comb begin
        fl_d = fl_q;
        if (fl_q.cnt == FL_W'(FL_HALF - 1)) begin
            fl_d.cnt   = '0;
            fl_d.phase = !fl_q.phase;
        end else begin
            fl_d.cnt = fl_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q.cnt   <= '0;
            fl_q.phase <= 1'b1;
        end else begin
            fl_q <= fl_d;
        end
    end

    sdc_pwm #(
        .DIV (DIM_DIV),
        .ON  (DIM_ON)
    ) u_dim (
        .clk  (clk),
        .rst  (rst),
        .on_o (pwm_on)
    );

    assign bcd_gate = bright || pwm_on;

    sdc_scan_bank #(
        .N_POS    (N_BCD),
        .DATA_W   (CODE_W),
        .DIV      (BCD_DIV),
        .RST_CELL (4'hF)
    ) u_bcd (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bcd_we),
        .wr_idx  (wr_addr[BCD_IW-1:0]),
        .wr_data (wr_data[CODE_W-1:0]),
        .gate_on (bcd_gate),
        .cell_o  (bcd_cell),
        .ptr_o   (bcd_ptr),
        .dig_o   (bcd_dig)
    );

    sdc_seg_decode u_dec (
        .code (bcd_cell),
        .seg  (bcd_seg)
    );

    sdc_scan_bank #(
        .N_POS    (N_RAW),
        .DATA_W   (SEG_W),
        .DIV      (RAW_DIV),
        .RST_CELL (7'h00)
    ) u_raw (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (raw_we),
        .wr_idx  (wr_addr[RAW_IW-1:0]),
        .wr_data (wr_data),
        .gate_on (1'b1),
        .cell_o  (raw_cell),
        .ptr_o   (raw_ptr),
        .dig_o   (raw_dig)
    );

    always_comb begin
        lamp_kill = '0;
        if ((raw_ptr == RAW_IW'(LAMP_POS)) && !fl_q.phase) begin
            lamp_kill = lamp_flash_en;
        end
        raw_seg = raw_cell & ~lamp_kill;
    end

    // R7: dimmed bank is dark outside the on part of the waveform
    a_r7_dim_dark: assert property (@(posedge clk) disable iff (rst)
        (!bright && !pwm_on) |-> (bcd_dig == '0));

    // R8: flash phase only moves at the end of a half period
    a_r8_phase_hold: assert property (@(posedge clk) disable iff (rst)
        (fl_q.cnt != '0) |-> $stable(fl_q.phase));

    // R9: a flashing lamp is dark in the off phase
    a_r9_lamp_dark: assert property (@(posedge clk) disable iff (rst)
        ((raw_ptr == RAW_IW'(LAMP_POS)) && !fl_q.phase) |-> ((raw_seg & lamp_flash_en) == '0));

    // R9: bits outside the lamp position pass unchanged
    a_r9_other_pass: assert property (@(posedge clk) disable iff (rst)
        (raw_ptr != RAW_IW'(LAMP_POS)) |-> (raw_seg == raw_cell));
endmodule

// File: tb/seg_display_ctrl_test.sv
module seg_display_ctrl_test;
    localparam int CLK_HZ = 1_200_000;
    localparam int BHZ = 10_000;
    localparam int RHZ = 12_000;
    localparam int DHZ = 120_000;
    localparam int FHZ = 20_000;
    localparam int BDIV = CLK_HZ / (BHZ * 6);
    localparam int RDIV = CLK_HZ / (RHZ * 4);
    localparam int DDIV = CLK_HZ / DHZ;
    localparam int DON  = (DDIV * 2) / 5;
    localparam int FHALF = (CLK_HZ / (2 * FHZ)) * 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [6:0] wr_data = '0;
    logic bright = 1'b1;
    logic [6:0] lamp_flash_en = '0;
    logic [6:0] bcd_seg, raw_seg;
    logic [5:0] bcd_dig;
    logic [3:0] raw_dig;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    seg_display_ctrl #(
        .CLK_HZ (CLK_HZ), .BCD_SCAN_HZ (BHZ), .RAW_SCAN_HZ (RHZ),
        .DIM_HZ (DHZ), .FLASH_DHZ (FHZ)
    ) uut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .bright (bright), .lamp_flash_en (lamp_flash_en),
        .bcd_seg (bcd_seg), .bcd_dig (bcd_dig), .raw_seg (raw_seg), .raw_dig (raw_dig)
    );

    // behavioural model
    int m_bmem[6];
    int m_rmem[4];
    int m_bcnt, m_bptr, m_rcnt, m_rptr, m_dcnt, m_fcnt;
    bit m_bgap, m_rgap, m_flash;

    function automatic int dec7(int c);
        case (c)
            0: return 'h3F; 1: return 'h06; 2: return 'h5B; 3: return 'h4F;
            4: return 'h66; 5: return 'h6D; 6: return 'h7D; 7: return 'h07;
            8: return 'h7F; 9: return 'h6F;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 6; i++) m_bmem[i] = 15;
            for (int i = 0; i < 4; i++) m_rmem[i] = 0;
            m_bcnt = 0; m_bptr = 0; m_bgap = 1;
            m_rcnt = 0; m_rptr = 0; m_rgap = 1;
            m_dcnt = 0; m_fcnt = 0; m_flash = 1;
        end else begin
            if (m_bcnt == BDIV - 1) begin
                m_bcnt = 0; m_bgap = 1; m_bptr = (m_bptr + 1) % 6;
            end else begin
                m_bcnt++; m_bgap = 0;
            end
            if (m_rcnt == RDIV - 1) begin
                m_rcnt = 0; m_rgap = 1; m_rptr = (m_rptr + 1) % 4;
            end else begin
                m_rcnt++; m_rgap = 0;
            end
            m_dcnt = (m_dcnt + 1) % DDIV;
            if (m_fcnt == FHALF - 1) begin
                m_fcnt = 0; m_flash = !m_flash;
            end else begin
                m_fcnt++;
            end
            if (wr_en) begin
                if (wr_addr < 6) m_bmem[wr_addr] = int'(wr_data[3:0]);
                else if (wr_addr >= 8 && wr_addr < 12) m_rmem[wr_addr - 8] = int'(wr_data);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            int ebd, erd, ers, kill;
            string t;
            ebd = 0;
            if (!m_bgap && (bright || m_dcnt < DON)) ebd = 1 << m_bptr;
            t = m_bgap ? "R6" : ((!bright && m_dcnt >= DON) ? "R7" : "R4");
            chk(t, int'(bcd_dig), ebd);
            chk(m_bmem[m_bptr] > 9 ? "R3 blank" : "R3 R2", int'(bcd_seg), dec7(m_bmem[m_bptr]));
            erd = m_rgap ? 0 : (1 << m_rptr);
            chk(m_rgap ? "R6" : "R5", int'(raw_dig), erd);
            kill = (m_rptr == 3 && !m_flash) ? int'(lamp_flash_en) : 0;
            ers = m_rmem[m_rptr] & ~kill & 'h7F;
            chk(m_rptr == 3 ? "R8 R9" : "R2", int'(raw_seg), ers);
        end
    end

    task automatic wr(int a, int d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 7'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", int'(bcd_dig), 0);
        chk("R1", int'(raw_dig), 0);
        chk("R1", int'(bcd_seg), 0);
        chk("R1", int'(raw_seg), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        idle(50);
        // R2 R3: digits 0..5
        for (int i = 0; i < 6; i++) wr(i, i);
        idle(300);
        // R7: dimming
        bright = 1'b0; idle(250); bright = 1'b1;
        // R3: digits 6..9 and blank codes
        wr(0, 6); wr(1, 7); wr(2, 8); wr(3, 9); wr(4, 10); wr(5, 15);
        idle(300);
        wr(0, 11); wr(1, 12); wr(2, 13); wr(3, 14); wr(4, 1); wr(5, 1);
        idle(200);
        // R5 R9: segment bank and lamps
        wr(8, 'h55); wr(9, 'h2A); wr(10, 'h7F); wr(11, 'h7F);
        lamp_flash_en = 7'b1010101;
        idle(1500);
        lamp_flash_en = 7'h00; idle(700);
        lamp_flash_en = 7'h7F; idle(700);
        wr(11, 'h0F); idle(700);
        // R2: holes in the address map change nothing
        wr(6, 'h7F); wr(7, 'h7F); wr(12, 'h00); wr(15, 'h00);
        idle(300);
        bright = 1'b0; lamp_flash_en = 7'h33; idle(800);
        finish_run();
    end
endmodule